// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block turns a virtual page number into a physical page number by fetching one 32-bit entry from an in-memory page table. When a walk request is accepted, it captures the table base value supplied by the processor together with the page number and the access type. It forms the entry address as base plus four times the page number and issues one read on a simple valid/ready memory request channel. The response may arrive any number of cycles later. The block then inspects the entry. A missing page is reported as a page fault. A write to a read-only page is reported as a protection fault. Otherwise the walk completes with the physical page number and the status flags of the entry as updated.

On a successful walk the block marks the entry as referenced, and for a write access also as modified. It stores the entry back to memory only when one of those bits actually changes. A faulting walk leaves memory untouched. Page offsets never enter the block: the requester keeps the low 12 address bits and joins them to the returned page number.

The controller is a six-state machine:
- ST_IDLE waits for a request and moves to ST_READ_PTE when it accepts one.
- ST_READ_PTE holds the read request until the memory accepts it, then moves to ST_WAIT_RESP.
- ST_WAIT_RESP waits for the read data. On arrival it goes to ST_FAULT for a page or protection fault, to ST_UPDATE_PTE when a status bit must change, and to ST_DONE otherwise.
- ST_UPDATE_PTE holds the write request until it is accepted, then moves to ST_DONE.
- ST_DONE and ST_FAULT each last one cycle and return to ST_IDLE.

Top module: `ptw_walker`

## Requirements
- R1: The read is issued to address `ptbr_base + 4*req_vpn`, using the base and page number captured in the cycle the request is accepted. Later changes on those inputs do not affect the walk in progress.
- R2: Entry bit layout is: bit 31 present, bit 30 referenced, bit 29 modified, bit 28 writable, bits 19:0 physical page number. If the entry is present and the access is permitted, `done` pulses. In that cycle `out_ppn` equals entry bits 19:0, and `out_flags` carries {present, referenced, modified, writable} of the updated entry, most significant first.
- R3: If the present bit is clear, `fault_page` pulses, `out_ppn` and `out_flags` are zero, and no write reaches memory.
- R4: On a successful walk the stored entry ends with its referenced bit at 1.
- R5: On a successful write access the stored entry also ends with its modified bit at 1. A read access leaves the modified bit as it was.
- R6: The entry is written back exactly once when the referenced or modified bit changes, and not at all when neither changes. The other entry bits are written back unchanged.
- R7: A write to a present entry whose writable bit is clear pulses `fault_prot`, never `fault_page`, with zero `out_ppn` and no write-back. A read of such an entry succeeds. A non-present entry reports `fault_page` whatever its writable bit.
- R8: Each accepted walk ends with exactly one of `done`, `fault_page` or `fault_prot` high for a single cycle. The block then returns to idle. `req_ready` is high only while idle.
- R9: A memory request stays asserted, with stable address, direction and data, until `mem_req_ready` is seen. The walk waits for `mem_rsp_valid` for as long as it takes.
- R10: After reset `req_ready` is 1, and `mem_req_valid`, `done`, `fault_page` and `fault_prot` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Walk request |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_vpn | input | VPN_W (20) | Virtual page number to translate |
| req_write | input | 1 | Access causing the walk is a write |
| ptbr_base | input | PA_W (32) | Page table base address |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = write-back, 0 = read |
| mem_req_addr | output | PA_W (32) | Entry byte address |
| mem_req_wdata | output | PTE_W (32) | Updated entry for write-back |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | PTE_W (32) | Entry read from memory |
| done | output | 1 | Translation complete pulse |
| fault_page | output | 1 | Page-not-present pulse |
| fault_prot | output | 1 | Write-protection pulse |
| out_ppn | output | PPN_W (20) | Physical page number, valid with `done` |
| out_flags | output | 4 | {present, referenced, modified, writable} with `done` |

## Verification
The hardest situation to reach is a walk whose memory handshake is slow on both sides. In that case the read request must stay stable while `mem_req_ready` is low, the base input changes under a walk already in flight, and the response comes many cycles later. A directed test holds the bench memory's ready low for several cycles and changes `ptbr_base` in the middle. It checks that the request holds its address, then releases ready and delivers the response with added latency. The other delicate cases come from the table of entries. These are entries whose bits already match, which must cause no write-back, and entries that are both absent and read-only, where the page fault must take precedence. The bench memory counts write-backs to check these cases.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ_PTE,
        ST_WAIT_RESP,
        ST_UPDATE_PTE,
        ST_DONE,
        ST_FAULT
    } ptw_state_e;

    typedef enum logic [1:0] {
        VERDICT_OK,
        VERDICT_OK_WB,
        VERDICT_PAGE_FAULT,
        VERDICT_PROT_FAULT
    } ptw_verdict_e;

    localparam int unsigned PTE_BIT_PRESENT  = 31;
    localparam int unsigned PTE_BIT_REF      = 30;
    localparam int unsigned PTE_BIT_DIRTY    = 29;
    localparam int unsigned PTE_BIT_WRITABLE = 28;
    localparam int unsigned FLAG_W           = 4;

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
    parameter int unsigned VPN_W       = 20,
    parameter int unsigned PA_W        = 32,
    parameter int unsigned ENTRY_BYTES = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [PA_W-1:0] base_in,
    input  logic [VPN_W-1:0] vpn_in,
    output logic [PA_W-1:0] entry_addr
);
    localparam int unsigned SHIFT = $clog2(ENTRY_BYTES);

    logic [PA_W-1:0]  base_q;
    logic [VPN_W-1:0] vpn_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            vpn_q  <= '0;
        end else if (load) begin
            base_q <= base_in;
            vpn_q  <= vpn_in;
        end
    end

    always_comb begin
        entry_addr = base_q + (PA_W'(vpn_q) << SHIFT);
    end

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(entry_addr)) else $error("entry address moved without a load"); // R1

endmodule

// File: rtl/ptw_pte_eval.sv
module ptw_pte_eval
    import ptw_pkg::*;
#(
    parameter int unsigned PTE_W = 32
) (
    input  logic [PTE_W-1:0] pte_in,
    input  logic             is_write,
    output ptw_verdict_e     verdict,
    output logic [PTE_W-1:0] pte_new
);
    always_comb begin
        pte_new              = pte_in;
        pte_new[PTE_BIT_REF] = 1'b1;
        if (is_write) begin
            pte_new[PTE_BIT_DIRTY] = 1'b1;
        end

        if (!pte_in[PTE_BIT_PRESENT]) begin
            verdict = VERDICT_PAGE_FAULT;
        end else if (is_write && !pte_in[PTE_BIT_WRITABLE]) begin
            verdict = VERDICT_PROT_FAULT;
        end else if (pte_new != pte_in) begin
            verdict = VERDICT_OK_WB;
        end else begin
            verdict = VERDICT_OK;
        end
    end

endmodule

// File: rtl/ptw_fsm.sv
module ptw_fsm
    import ptw_pkg::*;
#(
    parameter int unsigned PA_W  = 32,
    parameter int unsigned PTE_W = 32,
    parameter int unsigned PPN_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    output logic             req_ready,
    output logic             load,
    output logic             write_q,
    input  logic [PA_W-1:0]  entry_addr,
    input  ptw_verdict_e     verdict,
    input  logic [PTE_W-1:0] pte_new,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic             mem_req_write,
    output logic [PA_W-1:0]  mem_req_addr,
    output logic [PTE_W-1:0] mem_req_wdata,
    input  logic             mem_rsp_valid,
    output logic             done,
    output logic             fault_page,
    output logic             fault_prot,
    output logic [PPN_W-1:0] out_ppn,
    output logic [FLAG_W-1:0] out_flags
);
    ptw_state_e       state_q, state_d;
    logic [PTE_W-1:0] pte_upd_q;
    logic             prot_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (req_valid) state_d = ST_READ_PTE;
            ST_READ_PTE:   if (mem_req_ready) state_d = ST_WAIT_RESP;
            ST_WAIT_RESP: begin
                if (mem_rsp_valid) begin
                    unique case (verdict)
                        VERDICT_OK:         state_d = ST_DONE;
                        VERDICT_OK_WB:      state_d = ST_UPDATE_PTE;
                        VERDICT_PAGE_FAULT: state_d = ST_FAULT;
                        VERDICT_PROT_FAULT: state_d = ST_FAULT;
                        default:            state_d = ST_FAULT;
                    endcase
                end
            end
            ST_UPDATE_PTE: if (mem_req_ready) state_d = ST_DONE;
            ST_DONE:       state_d = ST_IDLE;
            ST_FAULT:      state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            pte_upd_q <= '0;
            prot_q    <= 1'b0;
            write_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (load) begin
                write_q <= req_write;
            end
            if (state_q == ST_WAIT_RESP && mem_rsp_valid) begin
                pte_upd_q <= pte_new;
                prot_q    <= (verdict == VERDICT_PROT_FAULT);
            end
        end
    end

    always_comb begin
        load          = (state_q == ST_IDLE) && req_valid;
        req_ready     = (state_q == ST_IDLE);
        mem_req_valid = (state_q == ST_READ_PTE) || (state_q == ST_UPDATE_PTE);
        mem_req_write = (state_q == ST_UPDATE_PTE);
        mem_req_addr  = entry_addr;
        mem_req_wdata = pte_upd_q;
        done          = (state_q == ST_DONE);
        fault_page    = (state_q == ST_FAULT) && !prot_q;
        fault_prot    = (state_q == ST_FAULT) && prot_q;
        out_ppn       = '0;
        out_flags     = '0;
        if (state_q == ST_DONE) begin
            out_ppn   = pte_upd_q[PPN_W-1:0];
            out_flags = {pte_upd_q[PTE_BIT_PRESENT], pte_upd_q[PTE_BIT_REF],
                         pte_upd_q[PTE_BIT_DIRTY],   pte_upd_q[PTE_BIT_WRITABLE]};
        end
    end

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, fault_page, fault_prot})) else $error("more than one outcome"); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fault_page || fault_prot) |=> !(done || fault_page || fault_prot)) else $error("outcome longer than a cycle"); // R8
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)
            && $stable(mem_req_write) && $stable(mem_req_wdata))) else $error("request dropped"); // R9
    AST_WB_SETS_REF: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_write) |-> mem_req_wdata[PTE_BIT_REF]) else $error("write-back without ref"); // R4
    AST_FAULT_NO_PPN: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_page || fault_prot) |-> (out_ppn == '0)) else $error("translation on fault"); // R3
    AST_PROT_WAS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        fault_prot |-> write_q) else $error("protection fault on read"); // R7

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int unsigned VPN_W = 20,
    parameter int unsigned PA_W  = 32,
    parameter int unsigned PTE_W = 32,
    parameter int unsigned PPN_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VPN_W-1:0]  req_vpn,
    input  logic              req_write,
    input  logic [PA_W-1:0]   ptbr_base,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [PA_W-1:0]   mem_req_addr,
    output logic [PTE_W-1:0]  mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [PTE_W-1:0]  mem_rsp_rdata,
    output logic              done,
    output logic              fault_page,
    output logic              fault_prot,
    output logic [PPN_W-1:0]  out_ppn,
    output logic [FLAG_W-1:0] out_flags
);
    localparam int unsigned ENTRY_BYTES = PTE_W / 8;

    logic             load;
    logic             write_q;
    logic [PA_W-1:0]  entry_addr;
    ptw_verdict_e     verdict;
    logic [PTE_W-1:0] pte_new;

    ptw_addr_gen #(
        .VPN_W(VPN_W), .PA_W(PA_W), .ENTRY_BYTES(ENTRY_BYTES)
    ) u_addr (
        .clk(clk), .rst_n(rst_n), .load(load),
        .base_in(ptbr_base), .vpn_in(req_vpn), .entry_addr(entry_addr)
    );

    ptw_pte_eval #(.PTE_W(PTE_W)) u_eval (
        .pte_in(mem_rsp_rdata), .is_write(write_q),
        .verdict(verdict), .pte_new(pte_new)
    );

    ptw_fsm #(.PA_W(PA_W), .PTE_W(PTE_W), .PPN_W(PPN_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_ready(req_ready),
        .load(load), .write_q(write_q), .entry_addr(entry_addr),
        .verdict(verdict), .pte_new(pte_new),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .done(done), .fault_page(fault_page), .fault_prot(fault_prot),
        .out_ppn(out_ppn), .out_flags(out_flags)
    );

    AST_RESULT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fault_page || fault_prot) |=> req_ready) else $error("no return to idle"); // R8

endmodule

// File: tb/ptw_walker_tb.sv
module ptw_walker_tb;
    localparam logic [31:0] BASE_A = 32'h0000_4000;
    localparam logic [31:0] BASE_B = 32'h0000_4040;
    localparam logic [31:0] P = 32'h8000_0000;
    localparam logic [31:0] R = 32'h4000_0000;
    localparam logic [31:0] D = 32'h2000_0000;
    localparam logic [31:0] W = 32'h1000_0000;
    localparam int K_DONE = 0, K_PAGE = 1, K_PROT = 2, K_NONE = 3;

    typedef struct packed {
        logic [5:0]  vpn;
        logic        wr;
        logic [31:0] pte_init;
        logic [1:0]  kind;
        logic [31:0] pte_after;
        logic        wb;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{6'd3,  1'b0, P|W|32'h12345,   2'd0, P|R|W|32'h12345,   1'b1},
        '{6'd5,  1'b1, P|W|32'hABCDE,   2'd0, P|R|D|W|32'hABCDE, 1'b1},
        '{6'd7,  1'b0, P|R|32'h00111,   2'd0, P|R|32'h00111,     1'b0},
        '{6'd9,  1'b1, P|R|D|W|32'h0F0F0, 2'd0, P|R|D|W|32'h0F0F0, 1'b0},
        '{6'd10, 1'b1, P|R|W|32'h22222, 2'd0, P|R|D|W|32'h22222, 1'b1},
        '{6'd12, 1'b0, R|32'h00033,     2'd1, R|32'h00033,       1'b0},
        '{6'd14, 1'b1, P|32'h00044,     2'd2, P|32'h00044,       1'b0},
        '{6'd15, 1'b1, 32'h00055,       2'd1, 32'h00055,         1'b0},
        '{6'd63, 1'b0, P|W|32'hFFFFF,   2'd0, P|R|W|32'hFFFFF,   1'b1},
        '{6'd0,  1'b0, P|R|D|32'h00001, 2'd0, P|R|D|32'h00001,   1'b0},
        '{6'd20, 1'b0, P|32'h00077,     2'd0, P|R|32'h00077,     1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [19:0] req_vpn = '0;
    logic req_write = 1'b0;
    logic [31:0] ptbr_base = BASE_A;
    logic mem_req_valid, mem_req_write;
    logic mem_req_ready = 1'b1;
    logic [31:0] mem_req_addr, mem_req_wdata;
    logic mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_rdata = '0;
    logic done, fault_page, fault_prot;
    logic [19:0] out_ppn;
    logic [3:0] out_flags;

    always #5 clk = ~clk;

    ptw_walker u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_vpn(req_vpn), .req_write(req_write), .ptbr_base(ptbr_base),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_rdata(mem_rsp_rdata), .done(done), .fault_page(fault_page),
        .fault_prot(fault_prot), .out_ppn(out_ppn), .out_flags(out_flags)
    );

    // bench memory: 64 words starting at BASE_A
    logic [31:0] mem [64];
    int wr_count = 0;
    int addr_err = 0;
    logic [31:0] last_rd_addr = '0;
    logic pend = 1'b0;
    int lat_cnt = 0;
    int rsp_lat = 0;
    logic [31:0] rd_hold = '0;

    function automatic int widx(input logic [31:0] a);
        logic [31:0] o;
        o = a - BASE_A;
        return int'(o[7:2]);
    endfunction

    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (mem_req_valid && mem_req_ready) begin
            if ((mem_req_addr - BASE_A) > 32'd252 || mem_req_addr[1:0] != 2'b00)
                addr_err <= addr_err + 1;
            if (mem_req_write) begin
                mem[widx(mem_req_addr)] <= mem_req_wdata;
                wr_count <= wr_count + 1;
            end else begin
                last_rd_addr <= mem_req_addr;
                rd_hold      <= mem[widx(mem_req_addr)];
                pend         <= 1'b1;
                lat_cnt      <= rsp_lat;
            end
        end else if (pend) begin
            if (lat_cnt == 0) begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_rdata <= rd_hold;
                pend          <= 1'b0;
            end else begin
                lat_cnt <= lat_cnt - 1;
            end
        end
    end

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // start a walk, wait for its outcome, verify one-cycle pulse and return to idle
    task automatic do_walk(input logic [31:0] base, input logic [19:0] vpn, input logic wr,
                           output int kind, output logic [19:0] ppn, output logic [3:0] flags,
                           output int wbs);
        int w0;
        int n;
        @(negedge clk);
        check(req_ready == 1'b1, "R8 ready before walk", 32'(req_ready), 32'd1);
        ptbr_base = base;
        req_vpn   = vpn;
        req_write = wr;
        req_valid = 1'b1;
        w0 = wr_count;
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R8 busy during walk", 32'(req_ready), 32'd0);
        n = 0;
        while (!(done || fault_page || fault_prot) && n < 60) begin
            @(negedge clk);
            n++;
        end
        kind  = done ? K_DONE : fault_page ? K_PAGE : fault_prot ? K_PROT : K_NONE;
        ppn   = out_ppn;
        flags = out_flags;
        check(n < 60, "R8 walk finished", 32'(n), 32'd60);
        check($countones({done, fault_page, fault_prot}) == 1, "R8 single outcome",
              32'({done, fault_page, fault_prot}), 32'd1);
        @(negedge clk);
        check(!(done || fault_page || fault_prot), "R8 one-cycle pulse",
              32'({done, fault_page, fault_prot}), 32'd0);
        check(req_ready == 1'b1, "R8 back to idle", 32'(req_ready), 32'd1);
        wbs = wr_count - w0;
    endtask

    initial begin
        #(200000 * 10);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int kind;
        logic [19:0] ppn;
        logic [3:0] flags;
        int wbs;
        logic [31:0] a0;

        for (int i = 0; i < 64; i++) mem[i] = 32'h0;
        repeat (3) @(negedge clk);
        // R10 reset state
        check(req_ready == 1'b1, "R10 ready in reset", 32'(req_ready), 32'd1);
        check({mem_req_valid, done, fault_page, fault_prot} == 4'b0, "R10 quiet in reset",
              32'({mem_req_valid, done, fault_page, fault_prot}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1 && !mem_req_valid, "R10 idle after reset",
              32'({req_ready, mem_req_valid}), 32'b10);

        // table walk
        for (int v = 0; v < NV; v++) begin
            vec_t e;
            e = VECS[v];
            mem[e.vpn] = e.pte_init;
            do_walk(BASE_A, {14'd0, e.vpn}, e.wr, kind, ppn, flags, wbs);
            check(last_rd_addr == BASE_A + {24'd0, e.vpn, 2'b00}, "R1 entry address",
                  last_rd_addr, BASE_A + {24'd0, e.vpn, 2'b00});
            check(kind == int'(e.kind), "R2 R3 R7 outcome kind", 32'(kind), 32'(e.kind));
            if (e.kind == 2'd0) begin
                check(ppn == e.pte_after[19:0], "R2 ppn", 32'(ppn), 32'(e.pte_after[19:0]));
                check(flags == e.pte_after[31:28], "R2 flags", 32'(flags), 32'(e.pte_after[31:28]));
            end else begin
                check(ppn == 20'd0 && flags == 4'd0, "R3 R7 no translation on fault",
                      32'({flags, ppn}), 32'd0);
            end
            check(wbs == int'(e.wb), "R6 write-back count", 32'(wbs), 32'(e.wb));
            check(mem[e.vpn] == e.pte_after, "R4 R5 stored entry", mem[e.vpn], e.pte_after);
        end

        // second base: vpn 2 under BASE_B lands at word 18
        mem[18] = P|W|32'h0ABCD;
        do_walk(BASE_B, 20'd2, 1'b1, kind, ppn, flags, wbs);
        check(last_rd_addr == BASE_B + 32'd8, "R1 other base", last_rd_addr, BASE_B + 32'd8);
        check(kind == K_DONE && ppn == 20'h0ABCD, "R2 other base ppn", 32'(ppn), 32'h0ABCD);
        check(mem[18] == (P|R|D|W|32'h0ABCD), "R5 dirty set via write", mem[18], P|R|D|W|32'h0ABCD);

        // repeat same walk: bits already set, no write-back
        do_walk(BASE_B, 20'd2, 1'b1, kind, ppn, flags, wbs);
        check(wbs == 0, "R6 no redundant write", 32'(wbs), 32'd0);

        // stalled memory, late response, base changed mid-walk
        mem[30] = P|W|32'h03030;
        mem_req_ready = 1'b0;
        rsp_lat = 4;
        @(negedge clk);
        ptbr_base = BASE_A;
        req_vpn   = 20'd30;
        req_write = 1'b0;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        ptbr_base = BASE_B;
        req_vpn   = 20'd1;
        a0 = mem_req_addr;
        check(mem_req_valid && !mem_req_write, "R9 read request raised",
              32'({mem_req_valid, mem_req_write}), 32'b10);
        check(a0 == BASE_A + 32'd120, "R1 captured address", a0, BASE_A + 32'd120);
        for (int s = 0; s < 3; s++) begin
            @(negedge clk);
            check(mem_req_valid && mem_req_addr == a0, "R9 request held", mem_req_addr, a0);
        end
        mem_req_ready = 1'b1;
        for (int s = 0; s < 5 && !done; s++) begin
            @(negedge clk);
            check(!done && !fault_page && !fault_prot, "R9 waits for response",
                  32'({done, fault_page, fault_prot}), 32'd0);
        end
        begin
            int n;
            n = 0;
            while (!done && n < 40) begin
                @(negedge clk);
                n++;
            end
        end
        check(done && out_ppn == 20'h03030, "R9 late response translated", 32'(out_ppn), 32'h03030);
        @(negedge clk);
        check(mem[30] == (P|R|W|32'h03030), "R4 ref after stalled walk", mem[30], P|R|W|32'h03030);
        rsp_lat = 0;

        check(addr_err == 0, "R1 addresses in table", 32'(addr_err), 32'd0);
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule